// File: doc/BRIEF.md
# Four-Function 12-bit Adder-Subtractor

This block is a purely combinational arithmetic unit. It takes two 12-bit operands, a 2-bit operation code and a single carry/borrow input. It returns a 12-bit result, the raw carry-out of its adder and a two's-complement overflow flag. All four operations run through one shared ripple adder: add, add with carry, subtract, and subtract with borrow. That adder is a chain of four 3-bit full-adder slices.

For the subtract codes, an operand conditioner inverts the second operand. The conditioner also builds the adder's carry input from both code bits and the external carry. The "+1" of two's complement therefore comes from the carry input, so no separate incrementer is needed. The carry/borrow input is active high in both roles. For subtraction, a carry-out of 1 means no borrow occurred.

Top module: `addsub12_unit`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals (`opnd_a` + `opnd_b`) mod 4096. `carry_out` is 1 exactly when the unsigned sum exceeds 4095.
- R2: With `op_sel` = 2'b01, `result` equals (`opnd_a` + `opnd_b` + `cy_in`) mod 4096. `carry_out` is 1 exactly when that unsigned sum exceeds 4095.
- R3: With `op_sel` = 2'b10, `result` equals (`opnd_a` − `opnd_b`) mod 4096. `carry_out` is 1 exactly when `opnd_a` ≥ `opnd_b` as unsigned values.
- R4: With `op_sel` = 2'b11, `result` equals (`opnd_a` − `opnd_b` − `cy_in`) mod 4096. `carry_out` is 1 exactly when `opnd_a` ≥ `opnd_b` + `cy_in` as unsigned values.
- R5: For codes 2'b00 and 2'b10, `cy_in` has no effect on any output.
- R6: `overflow` is 1 exactly when the true signed result leaves the range −2048..2047. Here the operands are read as 12-bit two's complement, and the true signed result is A+B(+c) or A−B(−c).
- R7: `overflow` is 0 whenever bit 11 of `opnd_a` differs from bit 11 of the effective second operand. The effective second operand is `opnd_b` for codes 2'b0x and ~`opnd_b` for codes 2'b1x.
- R8: A carry entering bit 0 ripples through every 3-bit slice to `carry_out`. For example, 0xFFF + 0x000 with code 2'b01 and `cy_in` = 1 gives `result` 0x000 and `carry_out` 1.
- R9: The outputs depend only on the present inputs: after any input change they settle with no clock, and earlier inputs leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 12 | First operand |
| opnd_b | input | 12 | Second operand, conditionally inverted |
| op_sel | input | 2 | Operation code: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| cy_in | input | 1 | Carry (add) or borrow (subtract), active high |
| result | output | 12 | Arithmetic result |
| carry_out | output | 1 | Raw adder carry-out; for subtraction 1 means no borrow |
| overflow | output | 1 | Signed overflow flag |

## Verification
The bench tries every operation code with both carry values over four kinds of operands, and each kind separates different faults:
- All pairs from a corner set (zero, one, 0x7FF, 0x800, all ones, alternating patterns) expose wrong sign handling and overflow polarity at the signed boundaries.
- A few thousand pseudo-random operand pairs catch mis-wired bits inside the slices.
- Directed all-ones and zero operands separate a broken inter-slice carry from a broken complementer.
- Pairs that differ only in the carry input, under the plain add and subtract codes, show whether the effective carry wrongly depends on the external carry.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int DATA_W  = 12;
    localparam int SLICE_W = 3;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } op_e;

    // Effective carry into bit 0: A - B - c = A + ~B + (1 - c)
    function automatic logic eff_carry(input op_e op, input logic cy);
        logic c;
        case (op)
            OP_ADD:  c = 1'b0;
            OP_ADC:  c = cy;
            OP_SUB:  c = 1'b1;
            default: c = ~cy;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addsub_slice.sv
module addsub_slice #(
    parameter int SW = addsub_pkg::SLICE_W
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          cin,
    output logic [SW-1:0] sum,
    output logic          cout
);

    logic [SW:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < SW; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    assign cout = c[SW];

    // R8: each slice is an exact SW-bit adder with carry
    always_comb begin
        p_slice_sum_r8: assert ({cout, sum} ==
                                ({1'b0, a} + {1'b0, b} + {{SW{1'b0}}, cin}))
            else $error("slice sum mismatch");
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int W  = addsub_pkg::DATA_W,
    parameter int SW = addsub_pkg::SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int NSL = W / SW;

    logic [NSL:0] chain;
    assign chain[0] = cin;

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        addsub_slice #(.SW(SW)) u_slice (
            .a    (a[s*SW +: SW]),
            .b    (b[s*SW +: SW]),
            .cin  (chain[s]),
            .sum  (sum[s*SW +: SW]),
            .cout (chain[s+1])
        );
    end

    assign cout = chain[NSL];

    // R8: the whole chain behaves as one W-bit adder
    always_comb begin
        p_chain_sum_r8: assert ({cout, sum} ==
                                ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("ripple chain mismatch");
    end

endmodule

// File: rtl/addsub_opsel.sv
module addsub_opsel
    import addsub_pkg::*;
#(
    parameter int W = addsub_pkg::DATA_W
) (
    input  logic [W-1:0] b_in,
    input  logic [1:0]   op,
    input  logic         cy,
    output logic [W-1:0] b_eff,
    output logic         c_eff
);

    op_e op_q;
    assign op_q  = op_e'(op);
    assign b_eff = op[1] ? ~b_in : b_in;
    assign c_eff = eff_carry(op_q, cy);

    // R5: plain add and subtract codes pin the carry regardless of cy
    always_comb begin
        if (op_q == OP_ADD)
            p_ceff_add_r5: assert (c_eff == 1'b0) else $error("add ceff");
        if (op_q == OP_SUB)
            p_ceff_sub_r5: assert (c_eff == 1'b1) else $error("sub ceff");
    end

endmodule

// File: rtl/addsub12_unit.sv
module addsub12_unit
    import addsub_pkg::*;
#(
    parameter int W  = addsub_pkg::DATA_W,
    parameter int SW = addsub_pkg::SLICE_W
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   op_sel,
    input  logic         cy_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c_eff;

    addsub_opsel #(.W(W)) u_opsel (
        .b_in  (opnd_b),
        .op    (op_sel),
        .cy    (cy_in),
        .b_eff (b_eff),
        .c_eff (c_eff)
    );

    addsub_ripple #(.W(W), .SW(SW)) u_ripple (
        .a    (opnd_a),
        .b    (b_eff),
        .cin  (c_eff),
        .sum  (result),
        .cout (carry_out)
    );

    // Same-sign operands with a flipped result sign
    assign overflow = (~opnd_a[MSB] & ~b_eff[MSB] &  result[MSB]) |
                      ( opnd_a[MSB] &  b_eff[MSB] & ~result[MSB]);

    always_comb begin
        // R1: plain add against an independent sum
        if (op_sel == 2'b00)
            p_add_r1: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
                else $error("add result");
        // R3: subtract as two's complement addition
        if (op_sel == 2'b10)
            p_sub_r3: assert ({carry_out, result} ==
                              ({1'b0, opnd_a} + {1'b0, ~opnd_b} + {{W{1'b0}}, 1'b1}))
                else $error("sub result");
        // R7: operands of opposite sign never overflow
        if (opnd_a[MSB] != b_eff[MSB])
            p_no_overflow_r7: assert (!overflow) else $error("spurious overflow");
        // R6: an overflow always shows a result sign unlike operand A
        if (overflow)
            p_ovf_sign_r6: assert (result[MSB] != opnd_a[MSB]) else $error("overflow sign");
    end

endmodule

// File: tb/sim_addsub12_unit.sv
module sim_addsub12_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] a, b;
    logic [1:0]  f;
    logic        c;
    logic [11:0] res;
    logic        co, ov;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    addsub12_unit u0 (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_sel    (f),
        .cy_in     (c),
        .result    (res),
        .carry_out (co),
        .overflow  (ov)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: a=%h b=%h f=%b c=%b actual %h expected %h",
                     tag, a, b, f, c, act, exp);
        end
    endtask

    // Drive one vector, let it settle, compare with arithmetic expectations
    task automatic run_vec(input logic [11:0] va, input logic [11:0] vb,
                           input logic [1:0] vf, input logic vc);
        int ai, bi, cc, t, sa, sb, st, er, eco, eov;
        string tg;
        a = va; b = vb; f = vf; c = vc;
        #2;
        ai = int'(va); bi = int'(vb);
        cc = vf[0] ? int'(vc) : 0;
        sa = va[11] ? ai - 4096 : ai;
        sb = vb[11] ? bi - 4096 : bi;
        if (!vf[1]) begin
            t   = ai + bi + cc;
            eco = (t > 4095) ? 1 : 0;
            st  = sa + sb + cc;
        end else begin
            t   = ai - bi - cc;
            eco = (t >= 0) ? 1 : 0;
            st  = sa - sb - cc;
        end
        er  = t & 4095;
        eov = (st > 2047 || st < -2048) ? 1 : 0;
        case (vf)
            2'b00:   tg = "R1";
            2'b01:   tg = "R2";
            2'b10:   tg = "R3";
            default: tg = "R4";
        endcase
        cmp({tg, " result"}, int'(res), er);
        cmp({tg, " carry"}, int'(co), eco);
        if (va[11] != (vf[1] ? ~vb[11] : vb[11]))
            cmp("R7 overflow", int'(ov), 0);
        else
            cmp("R6 overflow", int'(ov), eov);
    endtask

    logic [11:0] corners [10];

    initial begin
        int seed;
        logic [12:0] keep;
        corners = '{12'h000, 12'h001, 12'h002, 12'h7FE, 12'h7FF,
                    12'h800, 12'h801, 12'hFFF, 12'h555, 12'hAAA};
        a = '0; b = '0; f = 2'b00; c = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // quiescent state with all-zero inputs
        cmp("R1 idle result", int'(res), 0);
        cmp("R1 idle carry", int'(co), 0);
        cmp("R6 idle overflow", int'(ov), 0);

        // R1..R4, R6, R7: corner pairs, every code, both carries
        foreach (corners[i])
            foreach (corners[j])
                for (int k = 0; k < 8; k++)
                    run_vec(corners[i], corners[j], k[2:1], k[0]);

        // random operands
        seed = 7;
        for (int n = 0; n < 2500; n++) begin
            logic [11:0] ra, rb;
            ra = 12'($urandom(seed));
            seed = seed + 1;
            rb = 12'($urandom(seed));
            seed = seed + 1;
            for (int k = 0; k < 8; k++)
                run_vec(ra, rb, k[2:1], k[0]);
        end

        // R8: carry rippling through all four slices
        run_vec(12'hFFF, 12'h000, 2'b01, 1'b1);
        cmp("R8 ripple result", int'(res), 0);
        cmp("R8 ripple carry", int'(co), 1);
        run_vec(12'h000, 12'h000, 2'b11, 1'b1);
        cmp("R8 borrow result", int'(res), 12'hFFF);
        cmp("R8 borrow carry", int'(co), 0);

        // R5: cy_in must not move outputs for codes 00 and 10
        for (int n = 0; n < 300; n++) begin
            logic [11:0] ra, rb;
            ra = 12'($urandom(seed)); seed = seed + 1;
            rb = 12'($urandom(seed)); seed = seed + 1;
            for (int k = 0; k < 2; k++) begin
                logic [1:0] code;
                code = k[0] ? 2'b10 : 2'b00;
                a = ra; b = rb; f = code; c = 1'b0; #2;
                keep = {co, res};
                c = 1'b1; #2;
                cmp("R5 cy_in ignored", int'({co, res}), int'(keep));
                cmp("R5 overflow unchanged", int'(ov),
                    int'((ra[11] == (k[0] ? ~rb[11] : rb[11])) && (res[11] != ra[11])));
            end
        end

        // R9: outputs follow the present inputs, no history
        run_vec(12'hFFF, 12'hFFF, 2'b01, 1'b1);
        a = 12'h123; b = 12'h045; f = 2'b00; c = 1'b1;
        #1;
        cmp("R9 settle result", int'(res), 12'h168);
        cmp("R9 settle carry", int'(co), 0);
        cmp("R9 settle overflow", int'(ov), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule